// File: doc/BRIEF.md
# Prescaled Real-Time Timer with Alarm

This block keeps time from a slow timebase of nominally 32.768 kHz. Each edge of the slow clock is presented to it as a one-cycle enable, `slow_tick`, in the bus clock domain. A programmable 16-bit divider counts these ticks. Each time the divider completes its period, a free-running counter advances by one. A divider setting of 32768 gives one count per second. A divider setting of 0 stands for a full 65536-tick period.

Software sees four word registers on a simple memory-mapped bus:

- MODE (0x0): the divider setting, the two interrupt enables and a restart command.
- ALARM (0x4): the alarm value.
- COUNT (0x8): the counter, which is read-only.
- STATUS (0xC): two sticky flags, cleared when the register is read.

When the counter steps onto the alarm value, the alarm flag is raised. The flag drives a wake-up request that stays high until software reads STATUS. Each counter step also raises an increment flag. Each flag can be routed to its own interrupt output through an enable bit.

Top module: `rtt_top`

## Requirements
- R1: With a nonzero divider setting N in MODE bits [15:0], the counter advances by exactly one on every Nth `slow_tick`. It never changes on a cycle without a tick.
- R2: A divider setting of 0 gives one counter step per 65536 ticks.
- R3: The counter wraps from its all-ones value to 0 on the next step.
- R4: Writing 1 to MODE bit 18 (restart) leaves the counter untouched until the next tick. On that tick, both the divider phase and the counter become 0. Bit 18 always reads as 0.
- R5: When a counter step makes COUNT equal to ALARM, STATUS bit 0 (alarm flag) and `wake_req` rise on the same clock edge as the step.
- R6: Every counter step sets STATUS bit 1 (increment flag).
- R7: A read of STATUS (address 0xC) returns the flags and clears them on the same edge. A flag-setting event on that same edge is kept.
- R8: `wake_req` stays high until the alarm flag is cleared by a STATUS read.
- R9: `irq_alarm` equals the alarm flag gated by MODE bit 16. `irq_inc` equals the increment flag gated by MODE bit 17.
- R10: Writes to COUNT have no effect on the counter.
- R11: After reset:
  - COUNT reads 0 and STATUS reads 0.
  - MODE reads 0x8000 with both enables off.
  - ALARM reads all ones across the counter width.
  - All three outputs are low.
- R12: The bus returns read data one clock after the read is issued. A write takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock edge |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| wake_req | output | 1 | Sticky wake-up request from the alarm |
| irq_alarm | output | 1 | Gated alarm interrupt |
| irq_inc | output | 1 | Gated increment interrupt |

## Verification
Each counter step, and the flags and outputs it sets, appears on the clock edge that samples the final tick of a period. The bench therefore drives ticks from the falling edge and observes `wake_req` and the interrupts at the next falling edge. Read data is registered, so each register value is sampled one falling edge after the read strobe. Since that edge also clears the status flags, the flag outputs are checked after it. A restart is checked twice: the count is read back before the tick that applies the restart, and again after it. This shows the restart waits for the slow clock.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int MODE_EN_AL = 16;
  localparam int MODE_EN_IN = 17;
  localparam int MODE_RST   = 18;
  localparam int ST_ALARM   = 0;
  localparam int ST_INC     = 1;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_ALARM = 2'd1,
    REG_COUNT = 2'd2,
    REG_STAT  = 2'd3
  } reg_idx_t;
endpackage

// File: rtl/rtt_rst_sync.sv
module rtt_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [PRE_W-1:0] div,
  output logic             step
);
  logic [PRE_W-1:0] phase_q, phase_d, limit;
  logic             at_limit;

  // A zero setting means the full 2**PRE_W period.
  assign limit    = (div == '0) ? '1 : div - 1'b1;
  assign at_limit = (phase_q >= limit);
  assign step     = tick && !restart && at_limit;

  always_comb begin
    phase_d = phase_q;
    if (tick) begin
      if (restart || at_limit) phase_d = '0;
      else                     phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= phase_d;
  end

  // R1: the phase never moves without a tick
  p_phase_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q));
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [CNT_W-1:0] count_q, count_d, count_inc;

  assign count_inc = count_q + 1'b1;
  assign hit       = step && (count_inc == alarm);
  assign count     = count_q;

  always_comb begin
    count_d = count_q;
    if (clear)     count_d = '0;
    else if (step) count_d = count_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count_q <= '0;
    else if (clear || step) count_q <= count_d;
  end

  // R1 / R3: the count holds or moves by one, wrapping at the top
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (count_q == $past(count_q)) ||
               (count_q == CNT_W'($past(count_q) + 1'b1)));
endmodule

// File: rtl/rtt_regs.sv
module rtt_regs
  import rtt_pkg::*;
#(
  parameter int PRE_W     = 16,
  parameter int CNT_W     = 32,
  parameter int RESET_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              step,
  input  logic              hit,
  input  logic [CNT_W-1:0]  count,
  output logic [PRE_W-1:0]  div,
  output logic [CNT_W-1:0]  alarm,
  output logic              restart_tick,
  output logic              pend_restart,
  output logic              wake_req,
  output logic              irq_alarm,
  output logic              irq_inc
);
  reg_idx_t         idx;
  logic             wr_mode, wr_alarm, rd_stat;
  logic [PRE_W-1:0] div_q, div_d;
  logic             en_al_q, en_al_d, en_in_q, en_in_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] alarm_q, alarm_d;
  logic             f_al_q, f_al_d, f_in_q, f_in_d;
  logic [DATA_W-1:0] rd_q, rd_d;

  assign idx          = reg_idx_t'(addr[3:2]);
  assign wr_mode      = wr_en && (idx == REG_MODE);
  assign wr_alarm     = wr_en && (idx == REG_ALARM);
  assign rd_stat      = rd_en && (idx == REG_STAT);
  assign restart_tick = tick && pend_q;

  always_comb begin
    div_d   = div_q;
    en_al_d = en_al_q;
    en_in_d = en_in_q;
    if (wr_mode) begin
      div_d   = wr_data[PRE_W-1:0];
      en_al_d = wr_data[MODE_EN_AL];
      en_in_d = wr_data[MODE_EN_IN];
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (restart_tick)                    pend_d = 1'b0;
    if (wr_mode && wr_data[MODE_RST])    pend_d = 1'b1;
  end

  assign alarm_d = wr_alarm ? wr_data[CNT_W-1:0] : alarm_q;

  // Read clears, a new event on the same edge wins.
  assign f_al_d = (f_al_q && !rd_stat) || hit;
  assign f_in_d = (f_in_q && !rd_stat) || step;

  always_comb begin
    rd_d = '0;
    unique case (idx)
      REG_MODE: begin
        rd_d[PRE_W-1:0]  = div_q;
        rd_d[MODE_EN_AL] = en_al_q;
        rd_d[MODE_EN_IN] = en_in_q;
      end
      REG_ALARM: rd_d[CNT_W-1:0] = alarm_q;
      REG_COUNT: rd_d[CNT_W-1:0] = count;
      REG_STAT: begin
        rd_d[ST_ALARM] = f_al_q;
        rd_d[ST_INC]   = f_in_q;
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= PRE_W'(RESET_DIV);
      en_al_q <= 1'b0;
      en_in_q <= 1'b0;
    end else if (wr_mode) begin
      div_q   <= div_d;
      en_al_q <= en_al_d;
      en_in_q <= en_in_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alarm_q <= '1;
    else if (wr_alarm) alarm_q <= alarm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_al_q <= 1'b0;
      f_in_q <= 1'b0;
    end else begin
      f_al_q <= f_al_d;
      f_in_q <= f_in_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_en)  rd_q <= rd_d;
  end

  assign rd_data      = rd_q;
  assign div          = div_q;
  assign alarm        = alarm_q;
  assign pend_restart = pend_q;
  assign wake_req     = f_al_q;
  assign irq_alarm    = f_al_q && en_al_q;
  assign irq_inc      = f_in_q && en_in_q;

  // R5: an alarm hit is always visible on the next cycle
  p_hit_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> wake_req);
  // R8: wake request holds unless status is read
  p_wake_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req && !rd_stat |=> wake_req);
  // R7: a status read with no new event clears the flags
  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !hit && !step |=> !wake_req && !irq_inc);
endmodule

// File: rtl/rtt_top.sv
module rtt_top
  import rtt_pkg::*;
#(
  parameter int PRE_W     = 16,
  parameter int CNT_W     = 32,
  parameter int RESET_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wake_req,
  output logic              irq_alarm,
  output logic              irq_inc
);
  logic             rst_n_s;
  logic             step, hit, restart_tick, pend_restart;
  logic [PRE_W-1:0] div;
  logic [CNT_W-1:0] alarm, count;

  rtt_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  rtt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (slow_tick),
    .restart (pend_restart),
    .div     (div),
    .step    (step)
  );

  rtt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_s),
    .step  (step),
    .clear (restart_tick),
    .alarm (alarm),
    .count (count),
    .hit   (hit)
  );

  rtt_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W), .RESET_DIV(RESET_DIV)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .tick         (slow_tick),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .step         (step),
    .hit          (hit),
    .count        (count),
    .div          (div),
    .alarm        (alarm),
    .restart_tick (restart_tick),
    .pend_restart (pend_restart),
    .wake_req     (wake_req),
    .irq_alarm    (irq_alarm),
    .irq_inc      (irq_inc)
  );

  // R4: a restart applied on a tick leaves the counter at zero
  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    restart_tick |=> (count == '0));
  // R1: the counter only changes on a tick
  p_no_tick_hold_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !slow_tick |=> $stable(count));
endmodule

// File: tb/rtt_top_test.sv
module rtt_top_test;
  localparam int CW = 10;
  localparam logic [3:0] A_MODE = 4'h0, A_ALARM = 4'h4, A_COUNT = 4'h8, A_STAT = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        wake_req, irq_alarm, irq_inc;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  logic [31:0] v;

  always #5 clk = ~clk;

  rtt_top #(.PRE_W(16), .CNT_W(CW), .RESET_DIV(32768)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .wake_req(wake_req), .irq_alarm(irq_alarm), .irq_inc(irq_inc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic ticks(input int n);
    slow_tick = 1'b1;
    repeat (n) @(negedge clk);
    slow_tick = 1'b0;
  endtask

  task automatic restart_with(input logic [31:0] mode);
    wr(A_MODE, mode | 32'h0004_0000);
    ticks(1);
  endtask

  task automatic t_reset;
    rd(A_MODE, v);  chk("R11 mode", v, 32'h0000_8000);
    rd(A_ALARM, v); chk("R11 alarm", v, 32'h0000_03FF);
    rd(A_COUNT, v); chk("R11 count", v, 32'h0);
    rd(A_STAT, v);  chk("R11 status", v, 32'h0);
    chk("R11 outputs", {29'b0, wake_req, irq_alarm, irq_inc}, 32'h0);
  endtask

  task automatic t_prescale;
    restart_with(32'd3);
    rd(A_MODE, v);  chk("R4 restart bit reads 0", v, 32'd3);
    rd(A_STAT, v);
    ticks(2); rd(A_COUNT, v); chk("R1 count before period", v, 32'd0);
    ticks(1); rd(A_COUNT, v); chk("R1 first step", v, 32'd1);
    ticks(3); rd(A_COUNT, v); chk("R1 second step", v, 32'd2);
    rd(A_STAT, v); chk("R6 increment flag", v, 32'h2);
    rd(A_STAT, v); chk("R7 cleared on read", v, 32'h0);
    wr(A_COUNT, 32'h55);
    rd(A_COUNT, v); chk("R10 count write ignored", v, 32'd2);
  endtask

  task automatic t_restart;
    ticks(1);
    wr(A_MODE, 32'h0004_0003);
    repeat (3) @(negedge clk);
    rd(A_COUNT, v); chk("R4 count held before tick", v, 32'd2);
    ticks(1);
    rd(A_COUNT, v); chk("R4 count zero after tick", v, 32'd0);
    ticks(2); rd(A_COUNT, v); chk("R4 phase cleared", v, 32'd0);
    ticks(1); rd(A_COUNT, v); chk("R4 step after new period", v, 32'd1);
  endtask

  task automatic t_div0;
    restart_with(32'd0);
    ticks(65535); rd(A_COUNT, v); chk("R2 no step at 65535", v, 32'd0);
    ticks(1);     rd(A_COUNT, v); chk("R2 step at 65536", v, 32'd1);
  endtask

  task automatic t_wrap;
    restart_with(32'd1);
    ticks(1023); rd(A_COUNT, v); chk("R3 at max", v, 32'd1023);
    rd(A_STAT, v);
    ticks(1); rd(A_COUNT, v); chk("R3 wrapped", v, 32'd0);
    rd(A_STAT, v);
  endtask

  task automatic t_alarm;
    wr(A_ALARM, 32'd5);
    restart_with(32'h0001_0001);
    rd(A_STAT, v);
    ticks(4);
    chk("R5 no wake before match", {31'b0, wake_req}, 32'd0);
    ticks(1);
    chk("R5 wake on match", {31'b0, wake_req}, 32'd1);
    chk("R9 alarm irq enabled", {31'b0, irq_alarm}, 32'd1);
    chk("R9 inc irq disabled", {31'b0, irq_inc}, 32'd0);
    ticks(3);
    chk("R8 wake held", {31'b0, wake_req}, 32'd1);
    rd(A_STAT, v); chk("R5 status flags", v, 32'h3);
    chk("R8 wake cleared by read", {31'b0, wake_req}, 32'd0);
  endtask

  task automatic t_irq_inc;
    wr(A_ALARM, 32'd2);
    restart_with(32'h0002_0001);
    rd(A_STAT, v);
    ticks(2);
    chk("R9 inc irq enabled", {31'b0, irq_inc}, 32'd1);
    chk("R9 alarm irq masked", {30'b0, wake_req, irq_alarm}, 32'h2);
  endtask

  task automatic t_coincide;
    rd(A_STAT, v);
    addr = A_STAT; rd_en = 1'b1; slow_tick = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; slow_tick = 1'b0;
    chk("R7 read data before event", rd_data, 32'h0);
    chk("R7 event kept", {31'b0, irq_inc}, 32'd1);
    rd(A_STAT, v); chk("R7 flag survives read", v, 32'h2);
  endtask

  task automatic t_bus_timing;
    addr = A_ALARM; wr_data = 32'd77; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R12 read next cycle", rd_data, 32'd77);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_prescale;
    t_restart;
    t_div0;
    t_wrap;
    t_alarm;
    t_irq_inc;
    t_coincide;
    t_bus_timing;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule